// File: doc/BRIEF.md
# Signed-Count Bidirectional Arithmetic Shifter

This block shifts a 32-bit signed word in either direction by a single signed count. The count's sign picks the direction. A positive count moves the word toward the high end and fills the low bits with zeros. A negative count moves the word toward the low end and copies the sign bit into the high bits. A count of zero passes the word through unchanged.

A carry output holds the last bit that left the word. The result also drives a negative flag and a zero flag. All outputs are registered, and the result appears one cycle after the source and count are presented with the valid strobe.

A two-state controller tracks whether the output registers hold a fresh result:

- **ST_EMPTY**: no new result this cycle.
- **ST_FULL**: a result was captured on the last edge.

The transitions are:

- **T_LOAD**: ST_EMPTY to ST_FULL, or ST_FULL to ST_FULL, when `in_valid` is high.
- **T_DRAIN**: either state to ST_EMPTY when `in_valid` is low.

Reset puts the controller in ST_EMPTY.

Top module: `ashift_unit`

## Requirements
- R1: Only bits [6:0] of `count` are used, read as a two's-complement value from -64 to +63. Bits [31:7] have no effect on any output.
- R2: For a count of 1 to 31, `dst` is `src` shifted toward bit 31 by the count, with zeros entering at bit 0.
- R3: For a positive count, `carry` is the last bit pushed out past bit 31. For a count n of 1 to 32 this is `src[32-n]`.
- R4: For a count of -1 to -31, `dst` is `src` shifted toward bit 0 by the count's magnitude, with copies of `src[31]` entering at bit 31.
- R5: For a negative count of magnitude m from 1 to 32, `carry` is the last bit pushed out below bit 0, which is `src[m-1]`.
- R6: A count of zero in bits [6:0] gives `dst` equal to `src` and `carry` equal to 0.
- R7: A count from +32 to +63 gives `dst` equal to 0. `carry` is `src[0]` for +32 and 0 for larger counts.
- R8: A count from -32 to -64 gives every bit of `dst` equal to `src[31]`, and `carry` equal to `src[31]`.
- R9: `neg` equals bit 31 of `dst`. `zero` is 1 exactly when `dst` is all zeros.
- R10: A strobe on `in_valid` at one edge makes `out_valid` high for the following cycle with the new result. When `in_valid` is low, `out_valid` falls and `dst`, `carry`, `neg` and `zero` keep their values.
- R11: After reset, `out_valid`, `dst`, `carry`, `neg` and `zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Captures `src` and `count` at the next edge |
| src | input | 32 | Signed word to shift |
| count | input | 32 | Shift count word; only bits [6:0] matter |
| out_valid | output | 1 | High in the cycle after a capture |
| dst | output | 32 | Shifted result |
| carry | output | 1 | Last bit shifted out; 0 for a zero count |
| neg | output | 1 | Sign of `dst` |
| zero | output | 1 | `dst` is all zeros |

## Verification
The assertions assume that `in_valid`, `src` and `count` are known, not X, at each rising edge after reset. They also assume that a captured input is only judged in the cycle right after its capture. The stimulus changes inputs only on falling edges and always drives defined values. Idle gaps separate groups of strobes, so both back-to-back loads and the hold behaviour are exercised. Counts are chosen to reach every range boundary: 0, ±1, ±31, ±32, +33, +63 and -64. Some counts also carry junk in bits [31:7].

// File: rtl/ash_pkg.sv
package ash_pkg;
    localparam int ASH_DATA_W = 32;
    localparam int ASH_FIELD_W = 7;

    typedef enum logic [1:0] {
        SHF_NONE  = 2'd0,
        SHF_LEFT  = 2'd1,
        SHF_RIGHT = 2'd2
    } shf_dir_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ash_state_e;
endpackage

// File: rtl/ash_count_decode.sv
module ash_count_decode
    import ash_pkg::*;
#(
    parameter int CW = ASH_DATA_W,
    parameter int FW = ASH_FIELD_W
) (
    input  logic [CW-1:0] count_word,
    output shf_dir_e      dir,
    output logic [FW-1:0] mag
);
    logic [FW-1:0] field;

    assign field = count_word[FW-1:0];

    always_comb begin
        if (field == '0) begin
            dir = SHF_NONE;
            mag = '0;
        end else if (!field[FW-1]) begin
            dir = SHF_LEFT;
            mag = field;
        end else begin
            dir = SHF_RIGHT;
            mag = (~field) + 1'b1;  // magnitude fits unsigned, -64 gives 64
        end
    end
endmodule

// File: rtl/ash_shift_core.sv
module ash_shift_core
    import ash_pkg::*;
#(
    parameter int DW = ASH_DATA_W,
    parameter int MW = ASH_FIELD_W
) (
    input  logic [DW-1:0] src,
    input  shf_dir_e      dir,
    input  logic [MW-1:0] mag,
    output logic [DW-1:0] res,
    output logic          cout
);
    localparam int EW = DW + 1;

    logic [EW-1:0] lwide;
    logic [EW-1:0] rwide;

    // one guard bit above the word catches the last bit leaving the top
    assign lwide = {1'b0, src} << mag;
    // one guard bit below the word catches the last bit leaving the bottom
    assign rwide = $unsigned($signed({src, 1'b0}) >>> mag);

    always_comb begin
        unique case (dir)
            SHF_LEFT: begin
                res  = lwide[DW-1:0];
                cout = lwide[DW];
            end
            SHF_RIGHT: begin
                res  = rwide[EW-1:1];
                cout = rwide[0];
            end
            default: begin
                res  = src;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ash_flags.sv
module ash_flags #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] res,
    output logic          neg,
    output logic          zero
);
    assign neg  = res[DW-1];
    assign zero = ~|res;
endmodule

// File: rtl/ashift_unit.sv
module ashift_unit
    import ash_pkg::*;
#(
    parameter int DATA_W  = ASH_DATA_W,
    parameter int FIELD_W = ASH_FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] count,
    output logic              out_valid,
    output logic [DATA_W-1:0] dst,
    output logic              carry,
    output logic              neg,
    output logic              zero
);
    shf_dir_e           dir;
    logic [FIELD_W-1:0] mag;
    logic [DATA_W-1:0]  res_c;
    logic               cout_c;
    logic               neg_c;
    logic               zero_c;
    ash_state_e         state_q;
    ash_state_e         state_d;

    ash_count_decode #(.CW(DATA_W), .FW(FIELD_W)) u_dec (
        .count_word(count),
        .dir       (dir),
        .mag       (mag)
    );

    ash_shift_core #(.DW(DATA_W), .MW(FIELD_W)) u_core (
        .src (src),
        .dir (dir),
        .mag (mag),
        .res (res_c),
        .cout(cout_c)
    );

    ash_flags #(.DW(DATA_W)) u_flags (
        .res (res_c),
        .neg (neg_c),
        .zero(zero_c)
    );

    // next state: T_LOAD on a strobe, T_DRAIN otherwise
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // result registers load only on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst   <= '0;
            carry <= 1'b0;
            neg   <= 1'b0;
            zero  <= 1'b0;
        end else if (in_valid) begin
            dst   <= res_c;
            carry <= cout_c;
            neg   <= neg_c;
            zero  <= zero_c;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FULL: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && count[FIELD_W-1:0] == '0) |=> (dst == $past(src) && !carry));

    // R7
    left_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !count[FIELD_W-1] && count[FIELD_W-2:0] > (FIELD_W-1)'(DATA_W))
        |=> (dst == '0 && !carry));

    // R8
    right_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $signed(count[FIELD_W-1:0]) <= -DATA_W)
        |=> (dst == {DATA_W{$past(src[DATA_W-1])}} && carry == $past(src[DATA_W-1])));

    // R9
    flag_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (neg == dst[DATA_W-1]));

    // R9
    flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zero == (dst == '0)));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dst) && $stable(carry)));
endmodule

// File: tb/ashift_unit_test.sv
`timescale 1ns/1ps
module ashift_unit_test;
    typedef struct {
        logic [31:0] dst;
        logic        c;
        logic        n;
        logic        z;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src = '0;
    logic [31:0] count = '0;
    logic        out_valid;
    logic [31:0] dst;
    logic        carry;
    logic        neg;
    logic        zero;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #2 clk = ~clk;

    ashift_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .count(count),
        .out_valid(out_valid), .dst(dst), .carry(carry), .neg(neg), .zero(zero)
    );

    // bit-at-a-time reference
    function automatic exp_t model(logic [31:0] s, logic [31:0] cw, string tag);
        exp_t e;
        int   k;
        logic [31:0] d;
        logic        c;
        k = int'($signed(cw[6:0]));
        d = s;
        c = 1'b0;
        if (k > 0) begin
            for (int i = 0; i < k; i++) begin
                c = d[31];
                d = {d[30:0], 1'b0};
            end
        end else if (k < 0) begin
            for (int i = 0; i < -k; i++) begin
                c = d[0];
                d = {d[31], d[31:1]};
            end
        end
        e.dst = d;
        e.c   = c;
        e.n   = d[31];
        e.z   = (d == 32'h0);
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [31:0] s, input logic [31:0] cw, input string tag);
        exp_t e;
        @(negedge clk);
        src      = s;
        count    = cw;
        in_valid = 1'b1;
        e = model(s, cw, tag);
        sb_q.push_back(e);
        last_exp = e;
    endtask

    // R10: outputs must not move while in_valid is low
    task automatic idle_check;
        @(negedge clk);
        in_valid = 1'b0;
        src      = 32'hDEAD_BEEF;
        count    = 32'h0000_0005;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || dst !== last_exp.dst || carry !== last_exp.c) begin
            n_errors++;
            $display("FAIL R10 hold: ov=%b dst=%h c=%b expected ov=0 dst=%h c=%b",
                     out_valid, dst, carry, last_exp.dst, last_exp.c);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_errors++;
                $display("FAIL R10 unexpected result: dst=%h expected no result", dst);
            end else begin
                e = sb_q.pop_front();
                if (dst !== e.dst || carry !== e.c || neg !== e.n || zero !== e.z) begin
                    n_errors++;
                    $display("FAIL %s: dst=%h c=%b n=%b z=%b expected dst=%h c=%b n=%b z=%b",
                             e.tag, dst, carry, neg, zero, e.dst, e.c, e.n, e.z);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        n_checks++;
        if (out_valid !== 1'b0 || dst !== 32'h0 || carry !== 1'b0 || neg !== 1'b0 || zero !== 1'b0) begin
            n_errors++;
            $display("FAIL R11 reset: ov=%b dst=%h c=%b n=%b z=%b expected all 0",
                     out_valid, dst, carry, neg, zero);
        end
        rst_n = 1'b1;

        drive(32'h8000_0001, 32'h0000_0000, "R6 zero count");
        drive(32'h8000_0001, 32'h0000_0001, "R2 R3 left 1");
        drive(32'h0F00_0000, 32'h0000_0004, "R2 R3 left 4");
        drive(32'h0F00_0000, 32'h0000_0005, "R3 left 5 carry");
        idle_check();
        drive(32'h8000_0003, 32'hFFFF_FFFF, "R4 R5 right 1");
        drive(32'h7000_0008, 32'hFFFF_FFFC, "R4 R5 right 4");
        drive(32'h0000_0003, 32'h0000_001F, "R2 R3 left 31");
        drive(32'hC000_0000, 32'h0000_0061, "R4 R5 right 31");
        idle_check();
        drive(32'h1234_5678, 32'hFFFF_FF81, "R1 upper bits ignored (+1)");
        drive(32'h8765_4321, 32'h0000_0040, "R1 R8 field -64");
        drive(32'h8765_4321, 32'hABCD_EF80, "R1 R6 field zero");
        idle_check();
        drive(32'h0000_0001, 32'h0000_0020, "R7 left 32");
        drive(32'hFFFF_FFFF, 32'h0000_0021, "R7 left 33");
        drive(32'hFFFF_FFFF, 32'h0000_003F, "R7 left 63");
        drive(32'h8000_0000, 32'hFFFF_FFE0, "R8 right 32");
        drive(32'h7FFF_FFFF, 32'hFFFF_FFDF, "R8 right 33");
        drive(32'h0000_0000, 32'h0000_0003, "R9 zero flag");
        idle_check();
        for (int i = 0; i < 60; i++) begin
            drive($urandom, $urandom, "R2 R4 R9 random");
            if (i % 9 == 8) idle_check();
        end
        idle_check();
        repeat (3) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_errors++;
            $display("FAIL R10 missing results: %0d pending expected 0", sb_q.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule